// File: doc/BRIEF.md
# Framed Byte-Stream Link Transmitter

This block turns 104-bit parallel transactions into a framed byte stream for a point-to-point chip link. Transactions reach it on three channels: write, read request and read response. Each channel has a valid input (`*_access`) and a back-pressure output (`*_wait`). When the serializer is free, a fixed-priority arbiter picks one channel. The serializer then sends the packet as fourteen bytes, one per beat, and holds a frame signal high for the whole packet.

The far end pushes back with two asynchronous wait lines, one for writes and one for reads. Each line goes through a two-flop synchronizer before it can block a channel. A packet that is already on the wire always finishes. The block can also merge traffic into a burst. When this is enabled and a follow-on 64-bit write to the next doubleword address is waiting on the same channel, the frame stays high. The new transaction's data bytes then follow straight after the last byte of the current one, with no header.

Top module: `pkt_link_tx`

## Requirements
- R1: After reset, `link_frame` and `link_byte` are 0, and every `*_wait` output is 0 while the remote wait lines are low.
- R2: Byte 0 of a frame has bit 7 set when packet bit 0 (write) is 0. Bit 2 is set when `cfg_burst_en` is 1 and the packet is a 64-bit write (write=1, datamode bits [2:1]=2'b11). All other bits of byte 0 are 0.
- R3: Byte 1 is {ctrlmode (bits [6:3]), dstaddr[31:28]}. Bytes 2, 3 and 4 are dstaddr[27:20], [19:12] and [11:4]. Byte 5 is {dstaddr[3:0], datamode, write, 1'b1}. dstaddr is packet bits [39:8].
- R4: Bytes 6 to 9 are data (packet bits [71:40]), most significant byte first. Bytes 10 to 13 are packet bits [103:72] (srcaddr or upper data), most significant byte first.
- R5: A packet that is not merged into a burst keeps `link_frame` high for exactly 14 beats. Two such packets are separated by at least one beat with `link_frame` low.
- R6: When several channels are eligible at once, read response goes first, then write, then read request.
- R7: A channel's `*_wait` is low only in a cycle where the block takes that channel's packet if `*_access` is high. A packet is taken on a clock edge where `*_access` is high and `*_wait` is low, and `link_frame` is high on the next beat.
- R8: `rmt_wr_wait` blocks the write channel, and `rmt_rd_wait` blocks both read channels. Each takes effect through a two-stage synchronizer.
- R9: When a remote wait rises during a packet, the packet still goes out in full.
- R10: A burst forms when all of these hold: `cfg_burst_en` is 1; the current and the next packet are both 64-bit writes on the same channel; the next dstaddr equals the current dstaddr + 8; and ctrlmode is unchanged. Then the beat after byte 13 is byte 6 of the next packet, and `link_frame` stays high.
- R11: If burst is disabled, or the address is not sequential, the next packet starts a new frame with its full header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_burst_en | input | 1 | Allows burst merging of sequential 64-bit writes |
| wr_access | input | 1 | Write channel has a packet |
| wr_packet | input | 104 | Write channel packet |
| wr_wait | output | 1 | Write channel is not accepted this cycle |
| rq_access | input | 1 | Read-request channel has a packet |
| rq_packet | input | 104 | Read-request channel packet |
| rq_wait | output | 1 | Read-request channel is not accepted this cycle |
| rr_access | input | 1 | Read-response channel has a packet |
| rr_packet | input | 104 | Read-response channel packet |
| rr_wait | output | 1 | Read-response channel is not accepted this cycle |
| rmt_wr_wait | input | 1 | Asynchronous write back-pressure from the far end |
| rmt_rd_wait | input | 1 | Asynchronous read back-pressure from the far end |
| link_frame | output | 1 | Frame signal, high while packet bytes are on the link |
| link_byte | output | 8 | Link byte for the current beat |

## Verification
The hardest case to reach from the ports is the burst window. A qualifying 64-bit write has to be waiting on the same channel at exactly the edge that sends byte 13 of the previous write. The bench presents the follow-on write as soon as the first one is taken and holds `wr_access` high. The block's own `wr_wait` then releases it at that single edge, and the bench checks for an unbroken 22-byte frame. The second case is a remote wait that rises in the middle of a packet. The bench raises both wait lines one beat after a packet is taken, then checks that all 14 bytes still arrive. It also checks that a blocked channel stays stalled while an unblocked one goes through.

// File: rtl/link_tx_pkg.sv
// link_tx_pkg: shared constants and packet field helpers for the link
// transmitter. Assumes the fixed 104-bit packet layout described in the brief.
package link_tx_pkg;

    localparam int PKT_W      = 104;
    localparam int NUM_CH     = 3;
    localparam int CH_W       = $clog2(NUM_CH);
    localparam int BEATS      = 14;
    localparam int BEAT_W     = $clog2(BEATS);
    localparam int DATA_BEAT  = 6;
    localparam int LAST_BEAT  = BEATS - 1;

    // Channel indices double as priority: a lower index wins.
    localparam int CH_RR = 0;
    localparam int CH_WR = 1;
    localparam int CH_RQ = 2;

    // True for a 64-bit write (write=1, datamode=2'b11).
    function automatic logic is_dw_write(input logic [PKT_W-1:0] p);
        return p[0] && (p[2:1] == 2'b11);
    endfunction

    // True when nxt can follow cur inside a burst.
    function automatic logic burst_follows(input logic [PKT_W-1:0] cur,
                                           input logic [PKT_W-1:0] nxt);
        return is_dw_write(cur) && is_dw_write(nxt) &&
               (nxt[39:8] == cur[39:8] + 32'd8) && (nxt[6:3] == cur[6:3]);
    endfunction

    // Byte placed on the link at beat k of packet p.
    function automatic logic [7:0] beat_byte(input logic [PKT_W-1:0] p,
                                             input logic [BEAT_W-1:0] k,
                                             input logic burst_en);
        logic [7:0] b;
        case (k)
            4'd0:    b = {~p[0], 4'b0000, burst_en & is_dw_write(p), 2'b00};
            4'd1:    b = {p[6:3], p[39:36]};
            4'd2:    b = p[35:28];
            4'd3:    b = p[27:20];
            4'd4:    b = p[19:12];
            4'd5:    b = {p[11:8], p[2:1], p[0], 1'b1};
            4'd6:    b = p[71:64];
            4'd7:    b = p[63:56];
            4'd8:    b = p[55:48];
            4'd9:    b = p[47:40];
            4'd10:   b = p[103:96];
            4'd11:   b = p[95:88];
            4'd12:   b = p[87:80];
            4'd13:   b = p[79:72];
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/link_wait_sync.sv
// link_wait_sync: multi-flop synchronizer for asynchronous back-pressure
// lines. Assumes each input is a level that stays stable for several cycles.
module link_wait_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage samples the raw asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= raw_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage re-samples the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/link_tx_arb.sv
// link_tx_arb: fixed-priority channel selector for a new frame. Index 0 has
// the highest priority. A blocked channel is skipped and does not hide a
// lower one. Assumes 'open' is high only when a new frame may start.
module link_tx_arb #(
    parameter int NUM_CH = 3
) (
    input  logic              open,
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] blk,
    output logic [NUM_CH-1:0] ready
);
    logic [NUM_CH-1:0] elig;

    assign elig = req & ~blk;

    // A channel is ready if it is unblocked and no higher channel is eligible.
    always_comb begin
        logic higher;
        higher = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            ready[i] = open && !blk[i] && !higher;
            higher   = higher | elig[i];
        end
    end
endmodule

// File: rtl/link_tx_ser.sv
// link_tx_ser: packet serializer. Holds one packet, emits one byte per beat
// with a registered frame and byte, and reopens for a burst at the last beat.
// Assumes 'take' comes only while 'open' is high or 'at_last' is high.
module link_tx_ser
    import link_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_en,
    input  logic             take,
    input  logic [PKT_W-1:0] take_pkt,
    input  logic [CH_W-1:0]  take_ch,
    output logic             open,
    output logic             at_last,
    output logic [PKT_W-1:0] cur_pkt,
    output logic [CH_W-1:0]  cur_ch,
    output logic             link_frame,
    output logic [7:0]       link_byte
);
    logic              busy_q;
    logic [BEAT_W-1:0] idx_q;
    logic [PKT_W-1:0]  pkt_q;
    logic [CH_W-1:0]   ch_q;
    logic              frame_q;
    logic [7:0]        byte_q;

    assign open       = !busy_q && !frame_q;
    assign at_last    = busy_q && (idx_q == BEAT_W'(LAST_BEAT));
    assign cur_pkt    = pkt_q;
    assign cur_ch     = ch_q;
    assign link_frame = frame_q;
    assign link_byte  = byte_q;

    // Beat sequencer: start, step, burst continuation and end of frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            idx_q   <= '0;
            pkt_q   <= '0;
            ch_q    <= '0;
            frame_q <= 1'b0;
            byte_q  <= '0;
        end else if (!busy_q) begin
            if (take) begin
                pkt_q   <= take_pkt;
                ch_q    <= take_ch;
                busy_q  <= 1'b1;
                idx_q   <= BEAT_W'(1);
                frame_q <= 1'b1;
                byte_q  <= beat_byte(take_pkt, '0, burst_en);
            end else begin
                frame_q <= 1'b0;
                byte_q  <= '0;
            end
        end else begin
            frame_q <= 1'b1;
            byte_q  <= beat_byte(pkt_q, idx_q, burst_en);
            if (idx_q == BEAT_W'(LAST_BEAT)) begin
                if (take) begin
                    pkt_q <= take_pkt;
                    ch_q  <= take_ch;
                    idx_q <= BEAT_W'(DATA_BEAT);
                end else begin
                    busy_q <= 1'b0;
                end
            end else begin
                idx_q <= idx_q + BEAT_W'(1);
            end
        end
    end

    // Checker state: length of the current run of frame-high beats.
    logic [5:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= '0;
        else if (!frame_q)   run_q <= '0;
        else if (run_q != '1) run_q <= run_q + 6'd1;
    end

    // R2: the first beat of a frame carries only the read and burst flags.
    p_header_byte0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_frame) |-> ((link_byte & 8'h7B) == 8'h00));

    // R5, R9: a frame never ends before a complete packet has been sent.
    p_full_length_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_frame) |-> (run_q >= 6'(BEATS)));
endmodule

// File: rtl/pkt_link_tx.sv
// pkt_link_tx: three-channel packet-to-byte-stream link transmitter.
// Synchronizes remote waits, selects a channel with fixed priority, and
// serializes with optional burst merging. Assumes remote waits are levels.
module pkt_link_tx
    import link_tx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_burst_en,
    input  logic             wr_access,
    input  logic [PKT_W-1:0] wr_packet,
    output logic             wr_wait,
    input  logic             rq_access,
    input  logic [PKT_W-1:0] rq_packet,
    output logic             rq_wait,
    input  logic             rr_access,
    input  logic [PKT_W-1:0] rr_packet,
    output logic             rr_wait,
    input  logic             rmt_wr_wait,
    input  logic             rmt_rd_wait,
    output logic             link_frame,
    output logic [7:0]       link_byte
);
    logic [1:0]        sync_w;
    logic              wr_sync, rd_sync;
    logic [NUM_CH-1:0] acc, blk, arb_rdy, bst_rdy, rdy, accept;
    logic [PKT_W-1:0]  pk [NUM_CH];
    logic              open, at_last, take;
    logic [PKT_W-1:0]  cur_pkt, take_pkt;
    logic [CH_W-1:0]   cur_ch, take_ch;

    link_wait_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   ({rmt_rd_wait, rmt_wr_wait}),
        .sync_out (sync_w)
    );
    assign wr_sync = sync_w[0];
    assign rd_sync = sync_w[1];

    assign acc         = {rq_access, wr_access, rr_access};
    assign pk[CH_RR]   = rr_packet;
    assign pk[CH_WR]   = wr_packet;
    assign pk[CH_RQ]   = rq_packet;
    assign blk[CH_RR]  = rd_sync;
    assign blk[CH_WR]  = wr_sync;
    assign blk[CH_RQ]  = rd_sync;

    link_tx_arb #(.NUM_CH(NUM_CH)) i_arb (
        .open  (open),
        .req   (acc),
        .blk   (blk),
        .ready (arb_rdy)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Burst slot: same channel, last beat, unblocked, sequential 64-bit write.
        assign bst_rdy[c] = cfg_burst_en && at_last && (cur_ch == CH_W'(c)) &&
                            !blk[c] && burst_follows(cur_pkt, pk[c]);
        assign rdy[c]     = arb_rdy[c] | bst_rdy[c];
        assign accept[c]  = acc[c] & rdy[c];
    end

    assign rr_wait = !rdy[CH_RR];
    assign wr_wait = !rdy[CH_WR];
    assign rq_wait = !rdy[CH_RQ];
    assign take    = |accept;

    // Select the packet and the index of the accepted channel.
    always_comb begin
        take_pkt = '0;
        take_ch  = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (accept[i]) begin
                take_pkt = pk[i];
                take_ch  = CH_W'(i);
            end
        end
    end

    link_tx_ser i_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_en   (cfg_burst_en),
        .take       (take),
        .take_pkt   (take_pkt),
        .take_ch    (take_ch),
        .open       (open),
        .at_last    (at_last),
        .cur_pkt    (cur_pkt),
        .cur_ch     (cur_ch),
        .link_frame (link_frame),
        .link_byte  (link_byte)
    );

    // R6: a write never starts a frame while an unblocked read response waits.
    p_prio_rr_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_access && !wr_wait && !link_frame) |-> !(rr_access && !rd_sync));

    // R8: read channels are never taken while the synchronized read wait is high.
    p_rdwait_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((rq_access && !rq_wait) || (rr_access && !rr_wait)) |-> !rd_sync);

    // R7: a taken packet puts the frame high on the following beat.
    p_take_starts_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_access && !wr_wait) |=> link_frame);
endmodule

// File: tb/test_pkt_link_tx.sv
// test_pkt_link_tx: directed bench for pkt_link_tx. Each scenario task drives
// the channels, logs link bytes and checks its own results.
module test_pkt_link_tx;
    localparam int PW = 104;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_burst_en = 1'b0;
    logic          wr_access = 1'b0, rq_access = 1'b0, rr_access = 1'b0;
    logic [PW-1:0] wr_packet = '0, rq_packet = '0, rr_packet = '0;
    logic          wr_wait, rq_wait, rr_wait;
    logic          rmt_wr_wait = 1'b0, rmt_rd_wait = 1'b0;
    logic          link_frame;
    logic [7:0]    link_byte;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    pkt_link_tx i_pkt_link_tx (
        .clk (clk), .rst_n (rst_n), .cfg_burst_en (cfg_burst_en),
        .wr_access (wr_access), .wr_packet (wr_packet), .wr_wait (wr_wait),
        .rq_access (rq_access), .rq_packet (rq_packet), .rq_wait (rq_wait),
        .rr_access (rr_access), .rr_packet (rr_packet), .rr_wait (rr_wait),
        .rmt_wr_wait (rmt_wr_wait), .rmt_rd_wait (rmt_rd_wait),
        .link_frame (link_frame), .link_byte (link_byte)
    );

    // Link monitor: logs every frame-high byte, counts frames and run lengths.
    logic [7:0] lg [0:511];
    int nb = 0, nf = 0, last_len = 0, run = 0;
    logic prevf = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (link_frame) begin
                if (!prevf) nf++;
                if (nb < 512) lg[nb] = link_byte;
                nb++;
                run++;
            end else begin
                if (prevf) last_len = run;
                run = 0;
            end
            prevf = link_frame;
        end
    end

    function automatic logic [PW-1:0] mk(input logic wr, input logic [1:0] md,
        input logic [3:0] ct, input logic [31:0] dst, input logic [31:0] dat,
        input logic [31:0] src);
        return {src, dat, dst, 1'b0, ct, md, wr};
    endfunction

    // Expected byte k of packet p, written from R2, R3 and R4.
    function automatic logic [7:0] xb(input logic [PW-1:0] p, input int k, input logic be);
        logic [31:0] d, dt, s;
        d = p[39:8]; dt = p[71:40]; s = p[103:72];
        case (k)
            0:  return {~p[0], 4'b0, be & p[0] & (p[2:1] == 2'b11), 2'b0};
            1:  return {p[6:3], d[31:28]};
            2:  return d[27:20];
            3:  return d[19:12];
            4:  return d[11:4];
            5:  return {d[3:0], p[2:1], p[0], 1'b1};
            6:  return dt[31:24];
            7:  return dt[23:16];
            8:  return dt[15:8];
            9:  return dt[7:0];
            10: return s[31:24];
            11: return s[23:16];
            12: return s[15:8];
            default: return s[7:0];
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Compare logged bytes from beat k0 to 13 of p, starting at log index at.
    task automatic cmp_pkt(input int at, input logic [PW-1:0] p, input int k0,
                           input logic be, input string req);
        int bad = 0, fa = 0, fe = 0;
        for (int k = k0; k < 14; k++) begin
            int ix = at + k - k0;
            if (lg[ix] !== xb(p, k, be)) begin
                if (bad == 0) begin fa = lg[ix]; fe = xb(p, k, be); end
                bad++;
            end
        end
        chk(bad == 0, req, fa, fe);
    endtask

    // Offer packet p on channel ch until taken or tmo cycles pass.
    task automatic push(input int ch, input logic [PW-1:0] p, input int tmo, output bit ok);
        ok = 0;
        @(negedge clk);
        case (ch)
            0: begin rr_packet = p; rr_access = 1'b1; end
            1: begin wr_packet = p; wr_access = 1'b1; end
            default: begin rq_packet = p; rq_access = 1'b1; end
        endcase
        for (int i = 0; i < tmo; i++) begin
            logic w;
            #1;
            w = (ch == 0) ? rr_wait : (ch == 1) ? wr_wait : rq_wait;
            if (!w) begin
                @(posedge clk);
                #1;
                ok = 1;
                break;
            end
            @(negedge clk);
        end
        case (ch)
            0: rr_access = 1'b0;
            1: wr_access = 1'b0;
            default: rq_access = 1'b0;
        endcase
    endtask

    task automatic settle();
        repeat (30) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk(link_frame == 1'b0 && link_byte == 8'h00, "R1 idle link", {link_frame, link_byte}, 0);
        chk({wr_wait, rq_wait, rr_wait} == 3'b000, "R1 waits low", {wr_wait, rq_wait, rr_wait}, 0);
    endtask

    task automatic t_single_write();
        logic [PW-1:0] p = mk(1'b1, 2'b10, 4'h3, 32'h8080_0016, 32'h1122_3344, 32'hAABB_CCDD);
        int b0 = nb; bit ok;
        push(1, p, 20, ok);
        chk(ok, "R7 write taken", ok, 1);
        @(negedge clk); #1;
        chk(wr_wait && rr_wait && rq_wait, "R7 waits high while busy", {wr_wait, rr_wait, rq_wait}, 7);
        settle();
        chk(nb - b0 == 14 && last_len == 14, "R5 frame length", last_len, 14);
        chk(lg[b0] == 8'h00, "R2 write header byte0", lg[b0], 0);
        cmp_pkt(b0, p, 0, 1'b0, "R3 R4 write bytes");
    endtask

    task automatic t_read_req();
        logic [PW-1:0] p = mk(1'b0, 2'b10, 4'h0, 32'h8080_0004, 32'hDEAD_BEEF, 32'h810D_0004);
        int b0 = nb; bit ok;
        push(2, p, 20, ok);
        settle();
        chk(ok && lg[b0] == 8'h80, "R2 read header byte0", lg[b0], 8'h80);
        chk(lg[b0+10] == 8'h81 && lg[b0+13] == 8'h04, "R4 srcaddr bytes", lg[b0+13], 8'h04);
        cmp_pkt(b0, p, 0, 1'b0, "R3 R4 read bytes");
    endtask

    task automatic t_priority();
        logic [PW-1:0] a = mk(1'b1, 2'b10, 4'h1, 32'h0000_0100, 32'hA1A2_A3A4, 32'h0);
        logic [PW-1:0] b = mk(1'b1, 2'b10, 4'h2, 32'h0000_0200, 32'hB1B2_B3B4, 32'h0);
        logic [PW-1:0] c = mk(1'b0, 2'b10, 4'h0, 32'h0000_0300, 32'h0, 32'hC0C0_0001);
        int b0 = nb, f0 = nf; bit o1, o2, o3;
        fork
            push(2, c, 60, o3);
            push(1, b, 60, o2);
            push(0, a, 60, o1);
        join
        settle();
        chk(o1 && o2 && o3 && nb - b0 == 42, "R6 three packets sent", nb - b0, 42);
        chk(nf - f0 == 3, "R5 low beat between packets", nf - f0, 3);
        cmp_pkt(b0, a, 0, 1'b0, "R6 read response first");
        cmp_pkt(b0 + 14, b, 0, 1'b0, "R6 write second");
        cmp_pkt(b0 + 28, c, 0, 1'b0, "R6 read request last");
    endtask

    task automatic t_burst(input logic en, input logic [31:0] step);
        logic [PW-1:0] a = mk(1'b1, 2'b11, 4'h5, 32'h0000_1000, 32'h0102_0304, 32'h0506_0708);
        logic [PW-1:0] b = mk(1'b1, 2'b11, 4'h5, 32'h0000_1000 + step, 32'h1112_1314, 32'h1516_1718);
        int b0 = nb, f0 = nf; bit o1, o2;
        cfg_burst_en = en;
        push(1, a, 20, o1);
        push(1, b, 40, o2);
        settle();
        if (en && step == 8) begin
            chk(o1 && o2 && nb - b0 == 22 && nf - f0 == 1, "R10 merged frame", nb - b0, 22);
            chk(lg[b0] == 8'h04, "R2 burst flag byte0", lg[b0], 8'h04);
            cmp_pkt(b0, a, 0, 1'b1, "R10 first packet");
            cmp_pkt(b0 + 14, b, 6, 1'b1, "R10 continuation data");
        end else begin
            chk(o1 && o2 && nb - b0 == 28 && nf - f0 == 2, "R11 separate frames", nb - b0, 28);
            cmp_pkt(b0 + 14, b, 0, en, "R11 full header repeated");
        end
        cfg_burst_en = 1'b0;
    endtask

    task automatic t_remote_wait();
        logic [PW-1:0] w = mk(1'b1, 2'b10, 4'h0, 32'h0000_4000, 32'h4444_4444, 32'h0);
        logic [PW-1:0] q = mk(1'b0, 2'b10, 4'h0, 32'h0000_5000, 32'h0, 32'h5555_5555);
        int b0; bit ow, oq;
        rmt_wr_wait = 1'b1;
        repeat (3) @(negedge clk);
        b0 = nb;
        fork
            push(1, w, 25, ow);
            push(2, q, 25, oq);
        join
        settle();
        chk(!ow, "R8 write blocked by write wait", ow, 0);
        chk(oq && nb - b0 == 14, "R8 read passes during write wait", nb - b0, 14);
        rmt_wr_wait = 1'b0;
        rmt_rd_wait = 1'b1;
        repeat (3) @(negedge clk);
        push(0, q, 25, oq);
        chk(!oq, "R8 read response blocked by read wait", oq, 0);
        b0 = nb;
        push(1, w, 25, ow);
        settle();
        chk(ow && nb - b0 == 14, "R8 write passes during read wait", nb - b0, 14);
        rmt_rd_wait = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_mid_packet();
        logic [PW-1:0] p = mk(1'b1, 2'b10, 4'h0, 32'h0000_6000, 32'h6666_7777, 32'h0);
        int b0 = nb; bit ok;
        push(1, p, 20, ok);
        rmt_wr_wait = 1'b1;
        rmt_rd_wait = 1'b1;
        settle();
        chk(ok && nb - b0 == 14 && last_len == 14, "R9 packet completes", nb - b0, 14);
        cmp_pkt(b0, p, 0, 1'b0, "R9 bytes intact");
        rmt_wr_wait = 1'b0;
        rmt_rd_wait = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_single_write();
        t_read_req();
        t_priority();
        t_burst(1'b1, 32'd8);
        t_burst(1'b0, 32'd8);
        t_burst(1'b1, 32'd16);
        t_remote_wait();
        t_mid_packet();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule